// File: doc/BRIEF.md
# DAC Double-Buffer Load Controller

This block sits between a processor register bus and a digital-to-analog converter. Software writes a staging register. A holding register drives the converter code. A three-bit mode field in a 16-bit control register chooses what copies the staging value into the holding register. The choices are a rising edge on an external load pin, a falling edge on that pin, or a software write to the staging register. A square-wave mode instead switches the converter code between the staging and holding registers on opposite pin edges. This makes a two-level waveform from two values that are written once.

The load pin is asynchronous. It passes through a two-flop synchronizer and an edge detector. When the mode changes, the edge detector's history is re-seeded so that no stale edge is acted on. The block also tells the port logic whether the shared pin is currently used as the load input. The register bus is a plain single-cycle interface with no back-pressure: every write takes effect on the clock edge where the write enable is high, and read data is a combinational function of the address.

Top module: `dac_load_ctrl`

## Requirements
- R1: The control register sits at address 0 and is 16 bits wide. Only bits 6:4 (the mode field) can be written and read back. Every other bit reads 0, and writes to those bits have no effect. The staging register (address 1) and the holding register (address 2, read-only) read back zero-extended.
- R2: Reset clears the control register to 0000h and the staging and holding registers to 0. The converter code is therefore 0 after reset.
- R3: In mode 000, a rising edge on the load pin copies the staging register into the holding register, and the converter code follows. A pin level held for 3 clock cycles takes effect within 4. Falling edges and staging writes do not load.
- R4: Mode 100 behaves like mode 000, except that it loads on a falling edge of the load pin and ignores rising edges.
- R5: In mode 001, a bus write to the staging register loads the written value into the holding register on the same clock edge. The converter code shows it from the next cycle.
- R6: Mode 011 behaves exactly like mode 001. Staging bits above the code width are dropped.
- R7: In mode 101 (square wave), the holding register is never loaded. After a falling pin edge, the converter code tracks the staging register, including later writes to it. After a rising edge, the converter code shows the holding register.
- R8: On entry to mode 101, and until the first pin edge, the converter code keeps the value it had before entry.
- R9: In modes 010, 110 and 111, pin edges and staging writes do not move the holding register, and the converter code holds.
- R10: The pin-function enable output is 1 exactly in modes 000, 100 and 101, and 0 in the other five modes.
- R11: When the mode changes, a synchronized pin transition that arrives in the same cycle as the change is absorbed, not treated as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_addr | input | 2 | Register select: 0 control, 1 staging, 2 holding |
| bus_we | input | 1 | Write strobe, one write per cycle when high |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| load_pin_i | input | 1 | Asynchronous external load pin |
| pin_alt_en_o | output | 1 | High when the shared pin acts as the load input |
| dac_code_o | output | CODE_W | Code presented to the converter |

## Verification
The bench builds the block with its defaults: a 12-bit code, a 16-bit bus and a two-stage synchronizer. With a code narrower than the bus, a staging write with nonzero upper bits shows that those bits are dropped. With a two-stage synchronizer, the pin-to-load latency is short enough that the bench can time a pin transition to land exactly in the cycle where a mode change is seen, and so show that the stale edge is absorbed. A table walks through every mode in a sequence that leaves known, distinct values in the staging and holding registers. The square-wave entry case and the reserved modes therefore give a visible mismatch whenever a wrong source drives the code.

// File: rtl/dac_ld_pkg.sv
package dac_ld_pkg;

  typedef enum logic [2:0] {
    MD_PIN_RISE = 3'b000,
    MD_SW       = 3'b001,
    MD_RSV2     = 3'b010,
    MD_SW_ALIAS = 3'b011,
    MD_PIN_FALL = 3'b100,
    MD_SQUARE   = 3'b101,
    MD_RSV6     = 3'b110,
    MD_RSV7     = 3'b111
  } mode_e;

  localparam int MODE_LSB = 4;
  localparam int MODE_W   = 3;
  localparam int BUS_AW   = 2;

  localparam logic [BUS_AW-1:0] A_CTRL  = 2'd0;
  localparam logic [BUS_AW-1:0] A_STAGE = 2'd1;
  localparam logic [BUS_AW-1:0] A_HOLD  = 2'd2;

  function automatic logic mode_is_sw(input mode_e m);
    return (m == MD_SW) || (m == MD_SW_ALIAS);
  endfunction

  function automatic logic mode_uses_pin(input mode_e m);
    return (m == MD_PIN_RISE) || (m == MD_PIN_FALL) || (m == MD_SQUARE);
  endfunction

  function automatic logic mode_is_rsvd(input mode_e m);
    return (m == MD_RSV2) || (m == MD_RSV6) || (m == MD_RSV7);
  endfunction

endpackage

// File: rtl/dac_ld_regs.sv
module dac_ld_regs
  import dac_ld_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BUS_AW-1:0] addr_i,
  input  logic              we_i,
  input  logic [REG_W-1:0]  wdata_i,
  output mode_e             mode_o,
  output logic [CODE_W-1:0] stage_o,
  output logic              stage_wr_o,
  output logic [CODE_W-1:0] stage_wdata_o
);

  logic              ctrl_wr;
  logic              wdata_unused;
  mode_e             mode_q;
  logic [CODE_W-1:0] stage_q;

  assign ctrl_wr       = we_i && (addr_i == A_CTRL);
  assign stage_wr_o    = we_i && (addr_i == A_STAGE);
  assign stage_wdata_o = wdata_i[CODE_W-1:0];
  assign wdata_unused  = ^wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_PIN_RISE;
      stage_q <= '0;
    end else begin
      if (ctrl_wr)
        mode_q <= mode_e'(wdata_i[MODE_LSB +: MODE_W]);
      if (stage_wr_o)
        stage_q <= wdata_i[CODE_W-1:0];
    end
  end

  assign mode_o  = mode_q;
  assign stage_o = stage_q;

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (mode_o == $past(wdata_i[MODE_LSB +: MODE_W]))); // R1

  AST_STAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    stage_wr_o |=> (stage_o == $past(wdata_i[CODE_W-1:0]))); // R6

endmodule

// File: rtl/dac_ld_edge.sv
module dac_ld_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic clr_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_i};
      end
    end
  endgenerate

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise_o = !clr_i && lvl && !prev_q;
  assign fall_o = !clr_i && !lvl && prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R3

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R4

endmodule

// File: rtl/dac_ld_xfer.sv
module dac_ld_xfer
  import dac_ld_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode_i,
  input  logic              clr_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              stage_wr_i,
  input  logic [CODE_W-1:0] stage_wdata_i,
  input  logic [CODE_W-1:0] stage_i,
  output logic [CODE_W-1:0] hold_o,
  output logic [CODE_W-1:0] code_o
);

  logic [CODE_W-1:0] hold_q;
  logic              sel_stage_q;
  logic              sq_mode;

  assign sq_mode = (mode_i == MD_SQUARE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (mode_is_sw(mode_i)) begin
      if (stage_wr_i) hold_q <= stage_wdata_i;
    end else if (mode_i == MD_PIN_RISE) begin
      if (rise_i) hold_q <= stage_i;
    end else if (mode_i == MD_PIN_FALL) begin
      if (fall_i) hold_q <= stage_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sel_stage_q <= 1'b0;
    else if (!sq_mode || clr_i) sel_stage_q <= 1'b0;
    else if (fall_i)            sel_stage_q <= 1'b1;
    else if (rise_i)            sel_stage_q <= 1'b0;
  end

  assign hold_o = hold_q;
  assign code_o = sel_stage_q ? stage_i : hold_q;

  AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_is_sw(mode_i) && stage_wr_i) |=> (code_o == $past(stage_wdata_i))); // R5

  AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_is_rsvd(mode_i) |=> $stable(hold_q)); // R9

  AST_SQ_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sq_mode |=> $stable(hold_q)); // R7

  AST_SQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_mode && clr_i && $stable(hold_q)) |-> $stable(code_o)); // R8

endmodule

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
  import dac_ld_pkg::*;
#(
  parameter int REG_W       = 16,
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_we,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              load_pin_i,
  output logic              pin_alt_en_o,
  output logic [CODE_W-1:0] dac_code_o
);

  mode_e             mode;
  mode_e             mode_seen_q;
  logic              mode_chg;
  logic              rise;
  logic              fall;
  logic              stage_wr;
  logic [CODE_W-1:0] stage_wdata;
  logic [CODE_W-1:0] stage;
  logic [CODE_W-1:0] hold;

  dac_ld_regs #(.REG_W(REG_W), .CODE_W(CODE_W)) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_i       (bus_addr),
    .we_i         (bus_we),
    .wdata_i      (bus_wdata),
    .mode_o       (mode),
    .stage_o      (stage),
    .stage_wr_o   (stage_wr),
    .stage_wdata_o(stage_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_seen_q <= MD_PIN_RISE;
    else        mode_seen_q <= mode;
  end

  assign mode_chg = (mode != mode_seen_q);

  dac_ld_edge #(.STAGES(SYNC_STAGES)) edge_i (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (load_pin_i),
    .clr_i (mode_chg),
    .rise_o(rise),
    .fall_o(fall)
  );

  dac_ld_xfer #(.CODE_W(CODE_W)) xfer_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode),
    .clr_i        (mode_chg),
    .rise_i       (rise),
    .fall_i       (fall),
    .stage_wr_i   (stage_wr),
    .stage_wdata_i(stage_wdata),
    .stage_i      (stage),
    .hold_o       (hold),
    .code_o       (dac_code_o)
  );

  assign pin_alt_en_o = mode_uses_pin(mode);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[MODE_LSB +: MODE_W] = mode;
      A_STAGE: bus_rdata = REG_W'(stage);
      A_HOLD:  bus_rdata = REG_W'(hold);
      default: bus_rdata = '0;
    endcase
  end

  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[REG_W-1:MODE_LSB+MODE_W] == '0 &&
                              bus_rdata[MODE_LSB-1:0] == '0)); // R1

  AST_NO_EDGE_ON_CHG: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> !(rise || fall)); // R11

endmodule

// File: tb/dac_load_ctrl_tb_top.sv
`timescale 1ns/1ps
module dac_load_ctrl_tb_top;

  localparam int REG_W  = 16;
  localparam int CODE_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [REG_W-1:0]  bus_wdata = '0;
  logic [REG_W-1:0]  bus_rdata;
  logic              load_pin = 1'b0;
  logic              alt_en;
  logic [CODE_W-1:0] code;

  int n_checks = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_load_ctrl #(.REG_W(REG_W), .CODE_W(CODE_W), .SYNC_STAGES(2)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .load_pin_i  (load_pin),
    .pin_alt_en_o(alt_en),
    .dac_code_o  (code)
  );

  typedef struct packed {
    logic        is_pin;
    logic [1:0]  addr;
    logic [15:0] data;
    logic [11:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 16'h0010, 12'h000, 4'd5},  // R5 mode 001
    '{1'b0, 2'd1, 16'h0123, 12'h123, 4'd5},  // R5
    '{1'b0, 2'd0, 16'h0030, 12'h123, 4'd6},  // R6 mode 011
    '{1'b0, 2'd1, 16'hF456, 12'h456, 4'd6},  // R6 upper bits dropped
    '{1'b0, 2'd0, 16'h0000, 12'h456, 4'd3},  // R3 mode 000
    '{1'b0, 2'd1, 16'h0789, 12'h456, 4'd3},  // R3 write alone no load
    '{1'b1, 2'd0, 16'h0001, 12'h789, 4'd3},  // R3 rise loads
    '{1'b0, 2'd1, 16'h00AB, 12'h789, 4'd3},  // R3
    '{1'b1, 2'd0, 16'h0000, 12'h789, 4'd3},  // R3 fall ignored
    '{1'b0, 2'd0, 16'h0040, 12'h789, 4'd4},  // R4 mode 100
    '{1'b1, 2'd0, 16'h0001, 12'h789, 4'd4},  // R4 rise ignored
    '{1'b1, 2'd0, 16'h0000, 12'h0AB, 4'd4},  // R4 fall loads
    '{1'b0, 2'd1, 16'h0321, 12'h0AB, 4'd4},  // R4
    '{1'b0, 2'd0, 16'h0020, 12'h0AB, 4'd9},  // R9 mode 010
    '{1'b1, 2'd0, 16'h0001, 12'h0AB, 4'd9},  // R9
    '{1'b0, 2'd1, 16'h0654, 12'h0AB, 4'd9},  // R9
    '{1'b1, 2'd0, 16'h0000, 12'h0AB, 4'd9},  // R9
    '{1'b0, 2'd0, 16'h0050, 12'h0AB, 4'd8},  // R8 enter square, code holds
    '{1'b1, 2'd0, 16'h0001, 12'h0AB, 4'd7},  // R7 rise -> holding
    '{1'b1, 2'd0, 16'h0000, 12'h654, 4'd7},  // R7 fall -> staging
    '{1'b0, 2'd1, 16'h0777, 12'h777, 4'd7},  // R7 tracks staging
    '{1'b1, 2'd0, 16'h0001, 12'h0AB, 4'd7},  // R7 back to holding
    '{1'b0, 2'd0, 16'h0060, 12'h0AB, 4'd9},  // R9 mode 110
    '{1'b0, 2'd1, 16'h0111, 12'h0AB, 4'd9},  // R9
    '{1'b1, 2'd0, 16'h0000, 12'h0AB, 4'd9},  // R9
    '{1'b0, 2'd0, 16'h0070, 12'h0AB, 4'd9},  // R9 mode 111
    '{1'b1, 2'd0, 16'h0001, 12'h0AB, 4'd9}   // R9
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    rd(2'd0, r); chk("R2 ctrl", r, 16'h0000);
    rd(2'd2, r); chk("R2 holding", r, 16'h0000);
    chk("R2 code", 16'(code), 16'h0000);
    chk("R2 alt_en mode 000", 16'(alt_en), 16'h0001);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_pin) begin
        @(negedge clk);
        load_pin = VECS[i].data[0];
      end else begin
        wr(VECS[i].addr, VECS[i].data);
      end
      settle();
      n_checks++;
      if (code !== VECS[i].exp) begin
        n_bad++;
        $display("FAIL R%0d vector %0d: actual=%h expected=%h",
                 VECS[i].req, i, code, VECS[i].exp);
      end
    end

    // R4 fall in mode 100 loads staging 0x111
    wr(2'd0, 16'h0040);
    @(negedge clk); load_pin = 1'b0;
    settle();
    chk("R4 fall load", 16'(code), 16'h0111);
    wr(2'd1, 16'h05A5);
    settle();

    // R11 pin rise lands in the mode-change cycle and is absorbed
    @(negedge clk); load_pin = 1'b1;
    @(negedge clk); bus_addr = 2'd0; bus_wdata = 16'h0000; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    settle();
    chk("R11 stale edge absorbed", 16'(code), 16'h0111);
    @(negedge clk); load_pin = 1'b0;
    settle();
    @(negedge clk); load_pin = 1'b1;
    settle();
    chk("R3 later rise loads", 16'(code), 16'h05A5);

    // R1 control field only
    wr(2'd0, 16'hFFFF);
    rd(2'd0, r); chk("R1 ctrl all ones", r, 16'h0070);
    wr(2'd0, 16'hFF8F);
    rd(2'd0, r); chk("R1 ctrl reserved ignored", r, 16'h0000);
    wr(2'd1, 16'hFABC);
    rd(2'd1, r); chk("R1 staging readback", r, 16'h0ABC);
    wr(2'd2, 16'h0123);
    rd(2'd2, r); chk("R1 holding read-only", r, 16'h05A5);

    // R5 code shows written value the cycle after the write
    wr(2'd0, 16'h0010);
    wr(2'd1, 16'h02C4);
    chk("R5 next-cycle code", 16'(code), 16'h02C4);

    // R10 pin function enable per mode
    for (int m = 0; m < 8; m++) begin
      wr(2'd0, 16'(m << 4));
      chk("R10 alt_en", 16'(alt_en), 16'((m == 0 || m == 4 || m == 5) ? 1 : 0));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule